// File: doc/BRIEF.md
# Banked CPU Register File

This block holds the programmer-visible registers of a small 16-bit processor. Seven general registers exist twice, once in each of two banks: four data registers, two address registers and a frame base register. A bank-select bit in the flag register chooses which copy every access uses. The static base register, the user stack pointer, the interrupt stack pointer and the flag register exist only once.

The first two data registers can also be used as separate high and low bytes. Data registers 0 and 1 can each be joined with register 2 or 3 into a 32-bit value. A stack-pointer selector reaches either the user or the interrupt stack pointer, chosen by a stack-select bit in the flag register.

The block has one write port, two read ports and a dedicated flag-load input. Each read is registered. It shows the register contents after any write made in the same cycle.

Top module: `banked_regfile`

## Requirements
- R1: A cycle with `rst` high clears both banks, SB, USP, ISP and the flag register, and drives both read outputs to 0. After reset, bank 0 and the interrupt stack pointer are selected.
- R2: Selectors 0 to 6 (data regs 0 to 3, address regs 0 and 1, frame base) address the active bank. The active bank is `flags[4]` (0 = bank 0). A write changes only the active bank, and the inactive bank keeps its contents.
- R3: When `flag_we` loads a new bank bit, accesses in that same cycle still use the old bank. Accesses from the next cycle on use the new bank.
- R4: Size code 2'b10 is a 16-bit word access. Word reads come back zero-extended in `rd*_data[31:0]`.
- R5: Size 2'b00 accesses the low byte and 2'b01 the high byte, on selectors 0 and 1 only. A byte write takes `wr_data[7:0]` and leaves the other half unchanged. A byte read returns the byte in bits [7:0] with zeros above. A byte size on any other selector is not written and reads as 0.
- R6: Size 2'b11 on selector 0 accesses {reg2, reg0}, and on selector 1 it accesses {reg3, reg1}, with the upper 16 bits in the higher register. On any other selector a pair write is ignored and a pair read returns 0.
- R7: Selector 7 is SB, 9 is USP and 10 is ISP. Selector 8 is the active stack pointer: ISP when `flags[7]`=0, USP when 1. The flag value used is the one before any same-cycle flag load. These registers are not banked.
- R8: Selector 11 reads the flag register and cannot be written through the write port. The flag register loads `flag_wdata` when `flag_we` is high and is visible on `flags` after the edge.
- R9: Selectors 12 to 15 ignore writes and read as 0.
- R10: Read data appears on the cycle after the request. It reflects a register write or flag load made in the request cycle.
- R11: The two read ports are independent and may address any selector and size in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_we | input | 1 | Load the flag register |
| flag_wdata | input | 16 | New flag value |
| flags | output | 16 | Current flag register |
| wr_en | input | 1 | Write port enable |
| wr_sel | input | 4 | Write register selector |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data (bytes in [7:0], pair high half in [31:16]) |
| rd0_sel | input | 4 | Read port 0 selector |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_data | output | 32 | Read port 0 registered data |
| rd1_sel | input | 4 | Read port 1 selector |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_data | output | 32 | Read port 1 registered data |

## Verification
Two functions can fall in the same cycle: a bank switch through `flag_we`, and a write to a banked register that a read port addresses in that cycle. The write must land in the old bank and be forwarded to the read. The read in the following cycle must then see the new bank. Directed cycles apply a flag load, a write and a same-register read together. Long random runs make such collisions often. Every output is compared on each clock with a behavioural model that applies the old-bank write and then the flag load.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int SEL_W        = 4;
  localparam int NUM_BANKED   = 7;
  localparam int NUM_BANKS    = 2;
  localparam int NUM_HALF_REG = 2;
  localparam int PAIR_OFFSET  = 2;

  localparam logic [SEL_W-1:0] SEL_SB   = 4'd7;
  localparam logic [SEL_W-1:0] SEL_SP   = 4'd8;
  localparam logic [SEL_W-1:0] SEL_USP  = 4'd9;
  localparam logic [SEL_W-1:0] SEL_ISP  = 4'd10;
  localparam logic [SEL_W-1:0] SEL_FLG  = 4'd11;

  typedef enum logic [1:0] {
    SZ_LO   = 2'b00,
    SZ_HI   = 2'b01,
    SZ_WORD = 2'b10,
    SZ_PAIR = 2'b11
  } size_e;
endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode
  import rf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [1:0]               wr_size,
  input  logic [2*W-1:0]           wr_data,
  input  logic                     spsel,
  output logic [NUM_BANKED-1:0]    lo_we,
  output logic [NUM_BANKED-1:0]    hi_we,
  output logic [NUM_BANKED-1:0][W-1:0] lane_d,
  output logic                     sb_we,
  output logic                     usp_we,
  output logic                     isp_we
);
  localparam int H = W / 2;

  size_e sz;
  assign sz = size_e'(wr_size);

  for (genvar i = 0; i < NUM_BANKED; i++) begin : g_lane
    localparam logic [SEL_W-1:0] MY_SEL  = SEL_W'(i);
    localparam bit               HAS_HALF = (i < NUM_HALF_REG);
    localparam bit               IS_UPPER = (i >= PAIR_OFFSET) && (i < PAIR_OFFSET + NUM_HALF_REG);
    localparam logic [SEL_W-1:0] LOW_SEL = IS_UPPER ? SEL_W'(i - PAIR_OFFSET) : '1;

    always_comb begin
      lo_we[i]  = 1'b0;
      hi_we[i]  = 1'b0;
      lane_d[i] = wr_data[W-1:0];
      if (wr_en) begin
        unique case (sz)
          SZ_WORD: begin
            lo_we[i] = (wr_sel == MY_SEL);
            hi_we[i] = (wr_sel == MY_SEL);
          end
          SZ_LO: begin
            lo_we[i]  = HAS_HALF && (wr_sel == MY_SEL);
            lane_d[i] = {2{wr_data[H-1:0]}};
          end
          SZ_HI: begin
            hi_we[i]  = HAS_HALF && (wr_sel == MY_SEL);
            lane_d[i] = {2{wr_data[H-1:0]}};
          end
          SZ_PAIR: begin
            if (HAS_HALF && (wr_sel == MY_SEL)) begin
              lo_we[i] = 1'b1;
              hi_we[i] = 1'b1;
            end else if (IS_UPPER && (wr_sel == LOW_SEL)) begin
              lo_we[i]  = 1'b1;
              hi_we[i]  = 1'b1;
              lane_d[i] = wr_data[2*W-1:W];
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic word_wr;
  assign word_wr = wr_en && (sz == SZ_WORD);
  assign sb_we   = word_wr && (wr_sel == SEL_SB);
  assign usp_we  = word_wr && ((wr_sel == SEL_USP) || ((wr_sel == SEL_SP) && spsel));
  assign isp_we  = word_wr && ((wr_sel == SEL_ISP) || ((wr_sel == SEL_SP) && !spsel));
endmodule

// File: rtl/rf_bank_store.sv
module rf_bank_store
  import rf_pkg::*;
#(
  parameter int W      = 16,
  parameter int NB     = NUM_BANKED,
  parameter int NBANKS = NUM_BANKS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [((NBANKS > 1) ? $clog2(NBANKS) : 1)-1:0] bank,
  input  logic [NB-1:0]          lo_we,
  input  logic [NB-1:0]          hi_we,
  input  logic [NB-1:0][W-1:0]   lane_d,
  output logic [NB-1:0][W-1:0]   act_nxt
);
  localparam int H = W / 2;

  logic [W-1:0] mem [NBANKS][NB];

  for (genvar i = 0; i < NB; i++) begin : g_nxt
    logic [W-1:0] cur;
    assign cur        = mem[bank][i];
    assign act_nxt[i] = {hi_we[i] ? lane_d[i][W-1:H] : cur[W-1:H],
                         lo_we[i] ? lane_d[i][H-1:0] : cur[H-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBANKS; b++)
        for (int i = 0; i < NB; i++)
          mem[b][i] <= '0;
    end else begin
      for (int i = 0; i < NB; i++)
        mem[bank][i] <= act_nxt[i];
    end
  end
endmodule

// File: rtl/rf_sys_regs.sv
module rf_sys_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sb_we,
  input  logic         usp_we,
  input  logic         isp_we,
  input  logic [W-1:0] wdat,
  input  logic         flag_we,
  input  logic [W-1:0] flag_wdata,
  output logic [W-1:0] sb_nxt,
  output logic [W-1:0] usp_nxt,
  output logic [W-1:0] isp_nxt,
  output logic [W-1:0] flag_nxt,
  output logic [W-1:0] flag_q
);
  logic [W-1:0] sb_q, usp_q, isp_q;

  assign sb_nxt   = sb_we   ? wdat       : sb_q;
  assign usp_nxt  = usp_we  ? wdat       : usp_q;
  assign isp_nxt  = isp_we  ? wdat       : isp_q;
  assign flag_nxt = flag_we ? flag_wdata : flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sb_q   <= '0;
      usp_q  <= '0;
      isp_q  <= '0;
      flag_q <= '0;
    end else begin
      sb_q   <= sb_nxt;
      usp_q  <= usp_nxt;
      isp_q  <= isp_nxt;
      flag_q <= flag_nxt;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int W  = 16,
  parameter int NB = NUM_BANKED
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     sel,
  input  logic [1:0]           size,
  input  logic [NB-1:0][W-1:0] act_nxt,
  input  logic [W-1:0]         sb_nxt,
  input  logic [W-1:0]         usp_nxt,
  input  logic [W-1:0]         isp_nxt,
  input  logic [W-1:0]         flag_nxt,
  input  logic                 spsel,
  output logic [2*W-1:0]       rd_data
);
  localparam int H = W / 2;

  size_e        sz;
  logic [2*W-1:0] val;
  int           idx;

  assign sz  = size_e'(size);
  assign idx = int'(sel);

  always_comb begin
    val = '0;
    if (idx < NB) begin
      unique case (sz)
        SZ_WORD: val = {{W{1'b0}}, act_nxt[idx]};
        SZ_LO:   if (idx < NUM_HALF_REG) val = {{(2*W-H){1'b0}}, act_nxt[idx][H-1:0]};
        SZ_HI:   if (idx < NUM_HALF_REG) val = {{(2*W-H){1'b0}}, act_nxt[idx][W-1:H]};
        SZ_PAIR: if (idx < NUM_HALF_REG) val = {act_nxt[idx + PAIR_OFFSET], act_nxt[idx]};
        default: ;
      endcase
    end else if (sz == SZ_WORD) begin
      unique case (sel)
        SEL_SB:  val = {{W{1'b0}}, sb_nxt};
        SEL_SP:  val = {{W{1'b0}}, spsel ? usp_nxt : isp_nxt};
        SEL_USP: val = {{W{1'b0}}, usp_nxt};
        SEL_ISP: val = {{W{1'b0}}, isp_nxt};
        SEL_FLG: val = {{W{1'b0}}, flag_nxt};
        default: val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= val;
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int W         = 16,
  parameter int BANK_BIT  = 4,
  parameter int SPSEL_BIT = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flag_we,
  input  logic [W-1:0]     flag_wdata,
  output logic [W-1:0]     flags,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [1:0]       wr_size,
  input  logic [2*W-1:0]   wr_data,
  input  logic [SEL_W-1:0] rd0_sel,
  input  logic [1:0]       rd0_size,
  output logic [2*W-1:0]   rd0_data,
  input  logic [SEL_W-1:0] rd1_sel,
  input  logic [1:0]       rd1_size,
  output logic [2*W-1:0]   rd1_data
);
  localparam int NUM_RD = 2;
  localparam int BANK_IW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [W-1:0] flag_q, flag_nxt, sb_nxt, usp_nxt, isp_nxt;
  logic         spsel;
  logic [BANK_IW-1:0] bank;

  // R3 R7: bank and stack choice use the flag value before this cycle's load
  assign bank  = BANK_IW'(flag_q[BANK_BIT]);
  assign spsel = flag_q[SPSEL_BIT];
  assign flags = flag_q;

  logic [NUM_BANKED-1:0]         lo_we, hi_we;
  logic [NUM_BANKED-1:0][W-1:0]  lane_d, act_nxt;
  logic sb_we, usp_we, isp_we;

  rf_write_decode #(.W(W)) u_dec (
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data),
    .spsel(spsel), .lo_we(lo_we), .hi_we(hi_we), .lane_d(lane_d),
    .sb_we(sb_we), .usp_we(usp_we), .isp_we(isp_we)
  );

  rf_bank_store #(.W(W), .NB(NUM_BANKED), .NBANKS(NUM_BANKS)) u_banks (
    .clk(clk), .rst(rst), .bank(bank), .lo_we(lo_we), .hi_we(hi_we),
    .lane_d(lane_d), .act_nxt(act_nxt)
  );

  rf_sys_regs #(.W(W)) u_sys (
    .clk(clk), .rst(rst), .sb_we(sb_we), .usp_we(usp_we), .isp_we(isp_we),
    .wdat(wr_data[W-1:0]), .flag_we(flag_we), .flag_wdata(flag_wdata),
    .sb_nxt(sb_nxt), .usp_nxt(usp_nxt), .isp_nxt(isp_nxt),
    .flag_nxt(flag_nxt), .flag_q(flag_q)
  );

  logic [SEL_W-1:0] rsel  [NUM_RD];
  logic [1:0]       rsize [NUM_RD];
  logic [2*W-1:0]   rdat  [NUM_RD];

  assign rsel[0]  = rd0_sel;
  assign rsize[0] = rd0_size;
  assign rsel[1]  = rd1_sel;
  assign rsize[1] = rd1_size;
  assign rd0_data = rdat[0];
  assign rd1_data = rdat[1];

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port #(.W(W), .NB(NUM_BANKED)) u_rd (
      .clk(clk), .rst(rst), .sel(rsel[p]), .size(rsize[p]),
      .act_nxt(act_nxt), .sb_nxt(sb_nxt), .usp_nxt(usp_nxt), .isp_nxt(isp_nxt),
      .flag_nxt(flag_nxt), .spsel(spsel), .rd_data(rdat[p])
    );
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           flag_we,
  input logic [W-1:0]   flag_wdata,
  input logic [W-1:0]   flags,
  input logic           wr_en,
  input logic [3:0]     wr_sel,
  input logic [1:0]     wr_size,
  input logic [2*W-1:0] wr_data,
  input logic [3:0]     rd0_sel,
  input logic [1:0]     rd0_size,
  input logic [2*W-1:0] rd0_data,
  input logic [3:0]     rd1_sel,
  input logic [1:0]     rd1_size,
  input logic [2*W-1:0] rd1_data
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd0_data == '0 && rd1_data == '0 && flags == '0)); // R1

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_we) && !$past(rst)) |-> (flags == $past(flag_wdata))); // R8

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(flag_we) && !$past(rst)) |-> $stable(flags)); // R8

  AST_BAD_SEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rd0_sel) >= 4'd12) |-> (rd0_data == '0)); // R9

  AST_BAD_SEL_ZERO_P1: assert property (@(posedge clk) disable iff (rst)
    ($past(rd1_sel) >= 4'd12) |-> (rd1_data == '0)); // R9

  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
    ($past(rd0_size) < 2'd2) |-> (rd0_data[2*W-1:W/2] == '0)); // R5

  AST_WORD_ZEXT: assert property (@(posedge clk) disable iff (rst)
    ($past(rd0_size) == 2'd2) |-> (rd0_data[2*W-1:W] == '0)); // R4
endmodule

bind banked_regfile rf_checker #(.W(W)) u_chk (.*);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic        flag_we;
  logic [15:0] flag_wdata, flags;
  logic        wr_en;
  logic [3:0]  wr_sel, rd0_sel, rd1_sel;
  logic [1:0]  wr_size, rd0_size, rd1_size;
  logic [31:0] wr_data, rd0_data, rd1_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit started = 0;

  always #10 clk = ~clk;

  banked_regfile i_banked_regfile (.*);

  // behavioural model state
  logic [15:0] mb [2][7];
  logic [15:0] msb, musp, misp, mflg;
  logic [31:0] exp0, exp1;
  string tag0, tag1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] s, input logic [1:0] z, input bit b, input bit sp);
    logic [31:0] r = 32'h0;
    if (z == 2'b10) begin
      if (s < 7) r = {16'h0, mb[b][s]};
      else if (s == 7)  r = {16'h0, msb};
      else if (s == 8)  r = {16'h0, sp ? musp : misp};
      else if (s == 9)  r = {16'h0, musp};
      else if (s == 10) r = {16'h0, misp};
      else if (s == 11) r = {16'h0, mflg};
    end else if (s < 2) begin
      if (z == 2'b00) r = {24'h0, mb[b][s][7:0]};
      else if (z == 2'b01) r = {24'h0, mb[b][s][15:8]};
      else r = {mb[b][s + 2], mb[b][s]};
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] s, input logic [1:0] z, input string base);
    if (s >= 12) return "R9";
    if (s == 11) return "R8";
    if (s >= 7)  return "R7";
    if (z < 2)   return "R5";
    if (z == 3)  return "R6";
    if (wr_en && wr_sel == s) return "R10";
    if (flag_we) return "R3";
    if (s < 4)   return "R4";
    return base;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < 7; i++) mb[b][i] = 16'h0;
      msb = 0; musp = 0; misp = 0; mflg = 0;
      exp0 = 0; exp1 = 0; tag0 = "R1"; tag1 = "R1";
    end else begin
      bit ob, os;
      ob = mflg[4];
      os = mflg[7];
      if (wr_en) begin
        case (wr_size)
          2'b10: begin
            if (wr_sel < 7) mb[ob][wr_sel] = wr_data[15:0];
            else if (wr_sel == 7) msb = wr_data[15:0];
            else if (wr_sel == 8) begin
              if (os) musp = wr_data[15:0]; else misp = wr_data[15:0];
            end
            else if (wr_sel == 9)  musp = wr_data[15:0];
            else if (wr_sel == 10) misp = wr_data[15:0];
          end
          2'b00: if (wr_sel < 2) mb[ob][wr_sel][7:0]  = wr_data[7:0];
          2'b01: if (wr_sel < 2) mb[ob][wr_sel][15:8] = wr_data[7:0];
          default: if (wr_sel < 2) begin
            mb[ob][wr_sel]     = wr_data[15:0];
            mb[ob][wr_sel + 2] = wr_data[31:16];
          end
        endcase
      end
      if (flag_we) mflg = flag_wdata;
      exp0 = m_read(rd0_sel, rd0_size, ob, os);
      exp1 = m_read(rd1_sel, rd1_size, ob, os);
      tag0 = tag_of(rd0_sel, rd0_size, "R2");
      tag1 = tag_of(rd1_sel, rd1_size, "R11");
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check(tag0, rd0_data, exp0);
      check(tag1, rd1_data, exp1);
      check("R8", {16'h0, flags}, {16'h0, mflg});
    end
  end

  task automatic drive(input bit we, input logic [3:0] s, input logic [1:0] z, input logic [31:0] d,
                       input bit fwe, input logic [15:0] fd,
                       input logic [3:0] r0s, input logic [1:0] r0z,
                       input logic [3:0] r1s, input logic [1:0] r1z);
    @(negedge clk);
    wr_en = we; wr_sel = s; wr_size = z; wr_data = d;
    flag_we = fwe; flag_wdata = fd;
    rd0_sel = r0s; rd0_size = r0z; rd1_sel = r1s; rd1_size = r1z;
  endtask

  initial begin
    rst = 1; wr_en = 0; wr_sel = 0; wr_size = 0; wr_data = 0;
    flag_we = 0; flag_wdata = 0; rd0_sel = 0; rd0_size = 2; rd1_sel = 0; rd1_size = 2;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state visible at ports
    @(negedge clk);
    check("R1", rd0_data, 32'h0);
    check("R1", {16'h0, flags}, 32'h0);
    // R10: word write forwarded to same-cycle read
    drive(1, 0, 2'b10, 32'h0000_1234, 0, 0, 0, 2'b10, 0, 2'b00);
    // R5: byte halves
    drive(1, 0, 2'b00, 32'h0000_00AB, 0, 0, 0, 2'b10, 0, 2'b01);
    drive(1, 1, 2'b01, 32'h0000_00CD, 0, 0, 1, 2'b10, 1, 2'b01);
    // R6: pair write and read of upper register
    drive(1, 0, 2'b11, 32'hDEAD_BEEF, 0, 0, 0, 2'b11, 2, 2'b10);
    drive(1, 2, 2'b11, 32'h5555_6666, 0, 0, 2, 2'b10, 4, 2'b10);
    // R3: bank switch with a write in the same cycle (old bank), then new bank
    drive(1, 4, 2'b10, 32'h0000_A0A0, 1, 16'h0010, 4, 2'b10, 0, 2'b10);
    drive(1, 4, 2'b10, 32'h0000_B1B1, 0, 0, 4, 2'b10, 0, 2'b11);
    drive(0, 0, 2'b10, 0, 1, 16'h0000, 4, 2'b10, 6, 2'b10);
    drive(0, 0, 2'b10, 0, 0, 0, 4, 2'b10, 0, 2'b11);
    // R7: stack pointer alias both ways
    drive(1, 8, 2'b10, 32'h0000_1111, 0, 0, 10, 2'b10, 9, 2'b10);
    drive(1, 8, 2'b10, 32'h0000_2222, 1, 16'h0080, 8, 2'b10, 9, 2'b10);
    drive(1, 8, 2'b10, 32'h0000_3333, 0, 0, 8, 2'b10, 10, 2'b10);
    drive(1, 7, 2'b10, 32'h0000_7777, 0, 0, 7, 2'b10, 8, 2'b10);
    // R8 R9: ignored writes, illegal sizes
    drive(1, 11, 2'b10, 32'h0000_FFFF, 0, 0, 11, 2'b10, 12, 2'b10);
    drive(1, 13, 2'b10, 32'h0000_FFFF, 0, 0, 13, 2'b10, 4, 2'b00);
    drive(1, 4, 2'b00, 32'h0000_00EE, 0, 0, 4, 2'b10, 2, 2'b11);
    // random mix, R2 R11 and all of the above
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[0] | r[1], 4'($urandom_range(0, 15)), 2'($urandom), $urandom,
            (r[4:2] == 3'd0), 16'($urandom),
            4'($urandom_range(0, 12)), 2'($urandom),
            4'($urandom_range(0, 12)), 2'($urandom));
    end
    drive(0, 0, 2'b10, 0, 0, 0, 0, 2'b10, 1, 2'b10);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule